// File: doc/BRIEF.md
# Streaming Multiply-by-33 String Hasher

This block folds a stream of bytes into a 32-bit hash, one byte per clock. A start pulse loads the fixed seed 5381. Each accepted non-zero byte then updates the running value. The value is multiplied by 33 using a left shift by five plus the value itself, and the byte is combined in. Combining is either an add or an XOR, chosen byte by byte. All arithmetic wraps at 32 bits.

The string ends at its first zero byte. That byte is not folded into the hash. It raises the done flag, and the final hash is then held until the next start pulse. The block is meant to sit beside a byte source such as a parser or a receive path, hashing one null-terminated key per start.

Top module: `str_hash33`

## Requirements
- R1: After reset, hash_o is 5381 (0x00001505) and done_o is 0.
- R2: A start pulse without valid_i sets hash_o to 5381 and clears done_o from the next cycle, whatever state came before.
- R3: While a string is running, a non-zero byte with valid_i high and mode_xor_i = 0 makes the next hash_o equal to (hash_o * 33 + byte) mod 2^32.
- R4: While a string is running, a non-zero byte with valid_i high and mode_xor_i = 1 makes the next hash_o equal to ((hash_o * 33) mod 2^32) XOR byte, with the byte zero-extended.
- R5: A cycle with valid_i low and start_i low leaves hash_o and done_o unchanged.
- R6: A zero byte with valid_i high during a running string raises done_o in the next cycle and leaves hash_o unchanged, so an empty string yields 5381.
- R7: Once done_o is high, it stays high and hash_o stays fixed under any further bytes until the next start pulse.
- R8: When start_i and valid_i are high in the same cycle, the byte is folded onto the seed: the next hash_o is the R3/R4 result applied to 5381, or 5381 with done_o raised if the byte is zero.
- R9: Bytes offered after reset and before the first start pulse are ignored: hash_o stays 5381 and done_o stays 0.
- R10: mode_xor_i is sampled per byte, so add and XOR steps may alternate within one string.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new string; reloads the seed |
| valid_i | input | 1 | data_i holds a byte this cycle |
| data_i | input | 8 | String byte; zero terminates |
| mode_xor_i | input | 1 | 0: add the byte, 1: XOR the byte |
| hash_o | output | 32 | Running or final hash |
| done_o | output | 1 | Terminating zero byte seen |

## Verification
Two functions can land in the same cycle: the seed reload from start_i and the folding of a byte from valid_i, and the byte may also be the terminator. The bench raises start_i and valid_i together, once with a printable byte in each mode and once with a zero byte. It also does this right after a finished string, while done_o is still high. Each result is compared with a model that applies a single step to 5381, and the done flag is checked against whether the byte was zero.

// File: rtl/str_hash33_pkg.sv
package str_hash33_pkg;
  localparam int unsigned HASH_W_DEF = 32;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned SHIFT_DEF  = 5;
  localparam logic [31:0] SEED_DEF   = 32'd5381;

  typedef enum logic {
    COMB_ADD = 1'b0,
    COMB_XOR = 1'b1
  } comb_e;
endpackage

// File: rtl/str_hash33_step.sv
module str_hash33_step
  import str_hash33_pkg::*;
#(
  parameter int unsigned HASH_W = HASH_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned SHIFT  = SHIFT_DEF
) (
  input  logic [HASH_W-1:0] h_i,
  input  logic [DATA_W-1:0] c_i,
  input  comb_e             comb_i,
  output logic [HASH_W-1:0] h_o
);
  logic [HASH_W-1:0] c_ext;
  logic [HASH_W-1:0] scaled;

  generate
    if (DATA_W >= HASH_W) begin : g_trunc
      assign c_ext = c_i[HASH_W-1:0];
    end else begin : g_zext
      assign c_ext = {{(HASH_W-DATA_W){1'b0}}, c_i};
    end
  endgenerate

  // multiply by (2^SHIFT + 1) without a multiplier
  assign scaled = (h_i << SHIFT) + h_i;

  always_comb begin
    unique case (comb_i)
      COMB_XOR: h_o = scaled ^ c_ext;
      default:  h_o = scaled + c_ext;
    endcase
  end
endmodule

// File: rtl/str_hash33_ctrl.sv
module str_hash33_ctrl #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              load_o,
  output logic              fold_o,
  output logic              running_o,
  output logic              done_o
);
  logic running_q, done_q;
  logic take, is_zero, finish;

  assign is_zero = (data_i == '0);
  // start opens the window in the same cycle so a byte can ride with it
  assign take    = valid_i & (start_i | running_q);
  assign fold_o  = take & ~is_zero;
  assign finish  = take & is_zero;
  assign load_o  = start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      done_q    <= 1'b0;
    end else if (start_i) begin
      running_q <= ~finish;
      done_q    <= finish;
    end else if (finish) begin
      running_q <= 1'b0;
      done_q    <= 1'b1;
    end
  end

  assign running_o = running_q;
  assign done_o    = done_q;

  a_r7_run_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(running_q && done_q));
endmodule

// File: rtl/str_hash33.sv
module str_hash33
  import str_hash33_pkg::*;
#(
  parameter int unsigned HASH_W = HASH_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned SHIFT  = SHIFT_DEF,
  parameter logic [HASH_W-1:0] SEED = HASH_W'(SEED_DEF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              mode_xor_i,
  output logic [HASH_W-1:0] hash_o,
  output logic              done_o
);
  localparam logic [HASH_W-1:0] MULT = HASH_W'((1 << SHIFT) + 1);

  logic              load, fold, running;
  logic [HASH_W-1:0] hash_q, base, stepped;
  comb_e             comb;

  assign comb = mode_xor_i ? COMB_XOR : COMB_ADD;

  str_hash33_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .valid_i   (valid_i),
    .data_i    (data_i),
    .load_o    (load),
    .fold_o    (fold),
    .running_o (running),
    .done_o    (done_o)
  );

  assign base = load ? SEED : hash_q;

  str_hash33_step #(.HASH_W(HASH_W), .DATA_W(DATA_W), .SHIFT(SHIFT)) u_step (
    .h_i    (base),
    .c_i    (data_i),
    .comb_i (comb),
    .h_o    (stepped)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hash_q <= SEED;
    else if (load | fold) hash_q <= fold ? stepped : base;
  end

  assign hash_o = hash_q;

  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !start_i) |=> ($stable(hash_o) && $stable(done_o)));

  a_r2_start_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !valid_i) |=> (hash_o == SEED && !done_o));

  a_r3_add_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !start_i && valid_i && data_i != '0 && !mode_xor_i)
      |=> hash_o == HASH_W'($past(hash_o) * MULT + HASH_W'($past(data_i))));

  a_r4_xor_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !start_i && valid_i && data_i != '0 && mode_xor_i)
      |=> hash_o == (HASH_W'($past(hash_o) * MULT) ^ HASH_W'($past(data_i))));

  a_r6_zero_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !start_i && valid_i && data_i == '0) |=> (done_o && $stable(hash_o)));

  a_r7_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(hash_o)));
endmodule

// File: tb/tb_str_hash33.sv
module tb_str_hash33;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  data_i = 8'h00;
  logic        mode_xor_i = 1'b0;
  logic [31:0] hash_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  localparam logic [31:0] SEED = 32'd5381;

  always #2 clk_i = ~clk_i;  // 250 MHz

  str_hash33 dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .valid_i(valid_i),
    .data_i(data_i), .mode_xor_i(mode_xor_i), .hash_o(hash_o), .done_o(done_o)
  );

  function automatic logic [31:0] model(input logic [31:0] h, input logic [7:0] c, input logic x);
    logic [31:0] m = h * 32'd33;
    return x ? (m ^ {24'h0, c}) : (m + {24'h0, c});
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive for one cycle; outputs then reflect this cycle's inputs
  task automatic cyc(input logic s, input logic v, input logic [7:0] d, input logic x);
    start_i = s; valid_i = v; data_i = d; mode_xor_i = x;
    @(posedge clk_i); #1;
    start_i = 1'b0; valid_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 hash", hash_o, SEED);
    check("R1 done", {31'b0, done_o}, 32'd0);
  endtask

  task automatic t_idle_ignore;
    cyc(0, 1, 8'h41, 0);
    cyc(0, 1, 8'h00, 1);
    check("R9 hash", hash_o, SEED);
    check("R9 done", {31'b0, done_o}, 32'd0);
  endtask

  task automatic t_empty;
    cyc(1, 0, 8'h00, 0);
    check("R2 seed", hash_o, SEED);
    cyc(0, 1, 8'h00, 0);
    check("R6 empty hash", hash_o, SEED);
    check("R6 done", {31'b0, done_o}, 32'd1);
  endtask

  task automatic t_single(input logic x);
    logic [31:0] e = model(SEED, 8'h61, x);
    cyc(1, 0, 8'h00, 0);
    check("R2 done clear", {31'b0, done_o}, 32'd0);
    cyc(0, 1, 8'h61, x);
    check(x ? "R4 single" : "R3 single", hash_o, e);
    cyc(0, 1, 8'h00, x);
    check("R6 hash kept", hash_o, e);
  endtask

  task automatic t_long(input logic x);
    logic [31:0] e = SEED;
    cyc(1, 0, 8'h00, 0);
    for (int i = 0; i < 300; i++) begin
      logic [7:0] b = 8'($urandom_range(1, 255));
      cyc(0, 1, b, x);
      e = model(e, b, x);
      if (i % 50 == 7) begin
        cyc(0, 0, 8'h00, ~x);
        check("R5 gap", hash_o, e);
      end
    end
    cyc(0, 1, 8'h00, x);
    check(x ? "R4 long" : "R3 long", hash_o, e);
    check("R6 long done", {31'b0, done_o}, 32'd1);
  endtask

  task automatic t_done_hold;
    logic [31:0] h = hash_o;
    cyc(0, 1, 8'h55, 0);
    cyc(0, 1, 8'h00, 1);
    cyc(0, 1, 8'hff, 1);
    check("R7 hash held", hash_o, h);
    check("R7 done held", {31'b0, done_o}, 32'd1);
  endtask

  task automatic t_start_with_byte;
    cyc(1, 1, 8'h7a, 0);  // done is high here from the previous string
    check("R8 add fold", hash_o, model(SEED, 8'h7a, 0));
    check("R8 done low", {31'b0, done_o}, 32'd0);
    cyc(1, 1, 8'h7a, 1);
    check("R8 xor fold", hash_o, model(SEED, 8'h7a, 1));
    cyc(1, 1, 8'h00, 0);
    check("R8 zero hash", hash_o, SEED);
    check("R8 zero done", {31'b0, done_o}, 32'd1);
  endtask

  task automatic t_mixed;
    logic [31:0] e = SEED;
    cyc(1, 0, 8'h00, 0);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b = 8'(8'h30 + i);
      logic x = i[0] ^ i[2];
      cyc(0, 1, b, x);
      e = model(e, b, x);
    end
    cyc(0, 1, 8'h00, 0);
    check("R10 mixed", hash_o, e);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #9 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_idle_ignore();
    t_empty();
    t_single(0);
    t_single(1);
    t_long(0);
    t_done_hold();
    t_long(1);
    t_start_with_byte();
    t_mixed();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule